// File: doc/BRIEF.md
# Serial Dongle Register Access Master

The block lets a host read and write the indexed configuration registers of an infrared transceiver dongle. The link is bit-serial. The block drives a serial clock and a data-out line. It receives a data-in line and an active-low ready line from the dongle. Every level on the link is held for a whole number of time units. The length of one unit is `cfgDiv + 1` system clocks, so firmware can match the link speed to whatever dongle is fitted.

The host sets the operation code, the device address, the register index and the write data, then pulses `startIn`. The block runs one of three sequences:

- **Write:** a command byte, then a data byte, then a short tail.
- **Read:** a command byte, then a bounded poll of the ready line, then either an 8-bit sample or two dummy pulses, then a fixed trailer.
- **Dongle reset:** a long burst of clock pulses with data held low.

`busyOut` covers the whole access. `doneOut` marks its end for one cycle. A read whose poll runs out raises a sticky timeout flag and returns zero.

Top module: `dongle_link_master`

## Requirements
- R1: Every read or write opens with a lead pulse with data low. A preamble pulse with data high follows. Then the command byte is sent LSB first. The command byte is `devAddr | {regIdx,1'b0} | dir`, where dir is 1 for a write and 0 for a read. Data changes only while the clock is low, so every bit is valid at the rising clock edge.
- R2: With `opIn` = 2'b01 (write), the block sends the command byte, then a second preamble pulse with data high, then the data byte LSB first. It ends with 2 pulses with data low, which gives 21 rising clock edges in total.
- R3: With `opIn` = 2'b00 (read), the block polls `validN` after each of up to 10 pulses that follow the command byte. It stops at the first poll that sees `validN` low. It then samples `sdIn` on 8 falling clock edges, LSB first, and returns the byte on `rdData`. A read that sees valid at poll k gives 22+k rising edges.
- R4: If `validN` is still high after the 10th poll, the read gives 2 dummy pulses instead of sampling. It returns `rdData` = 0, raises `timeoutOut`, and gives 26 rising edges in total.
- R5: Every read ends with 1 pulse, then data driven low, then 3 more pulses. The last three rising edges of a read therefore carry data low.
- R6: With `opIn[1]` = 1 (dongle reset), the block drives data low and issues 30 full clock pulses.
- R7: Every clock-high phase lasts one unit, which is `cfgDiv`+1 system clocks. In a byte, the setup phase before each rising edge lasts two units. In the dongle-reset burst, each low phase lasts one unit.
- R8: `busyOut` rises after an accepted start and falls in the same cycle that `doneOut` pulses. `doneOut` is one cycle wide. A `startIn` that arrives while the block is busy has no effect.
- R9: The serial clock is low whenever the block is idle, and it moves only during an access.
- R10: `timeoutOut` stays set until `timeoutClr` is high. A clear takes effect when no timeout is raised in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgDiv | input | DIV_W | Time unit length minus one, in system clocks |
| startIn | input | 1 | Start pulse, accepted only when idle |
| opIn | input | 2 | Operation code: 00 read, 01 write, 1x dongle reset |
| devAddr | input | 8 | Device address merged into the command byte |
| regIdx | input | 7 | Register index, shifted left by one into the command byte |
| wrData | input | 8 | Data byte for a write |
| timeoutClr | input | 1 | Clears the sticky timeout flag |
| validN | input | 1 | Active-low ready line from the dongle |
| sdIn | input | 1 | Serial data from the dongle |
| sclkOut | output | 1 | Serial clock to the dongle |
| sdOut | output | 1 | Serial data to the dongle |
| rdData | output | 8 | Result of the last read |
| busyOut | output | 1 | High while an access runs |
| doneOut | output | 1 | One-cycle end-of-access pulse |
| timeoutOut | output | 1 | Sticky poll timeout flag |

## Verification
The bench sweeps every poll depth from the first poll to the last, plus a dongle that never answers, at several divider settings.

- An off-by-one in the poll bound shows up as a wrong edge count. It also shows up as a false timeout, or as a missed timeout at poll ten.
- A sample taken on the wrong clock edge shows up as a shifted read byte.
- A wrong unit counter shows up in the measured high and low phase lengths.
- A second start issued mid-access would corrupt the logged write stream. It would also add clock edges after `doneOut`.

// File: rtl/dlm_pkg.sv
package dlm_pkg;

  localparam int BYTE_W      = 8;
  localparam int UNIT_W      = 2;
  localparam int LONG_UNITS  = 2;
  localparam int SHORT_UNITS = 1;

  typedef enum logic [1:0] {
    SD_LOW  = 2'd0,
    SD_HIGH = 2'd1,
    SD_TX   = 2'd2
  } dataSel_t;

  typedef struct packed {
    logic              startAcc;
    logic              dirWrite;
    logic              load;
    logic [UNIT_W-1:0] units;
    logic              setClk;
    logic              clkVal;
    logic              setData;
    dataSel_t          dataSel;
    logic              loadData;
    logic              shiftTx;
    logic              sampleRx;
    logic              raiseTo;
    logic              latchRd;
    logic              stop;
  } stepCtl_t;

  function automatic int maxOf(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dlm_datapath.sv
module dlm_datapath
  import dlm_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [DIV_W-1:0]    cfgDiv,
  input  logic [BYTE_W-1:0]   devAddr,
  input  logic [BYTE_W-2:0]   regIdx,
  input  logic [BYTE_W-1:0]   wrData,
  input  logic                timeoutClr,
  input  logic                sdIn,
  input  stepCtl_t            ctl,
  output logic                stepDone,
  output logic                sclkOut,
  output logic                sdOut,
  output logic [BYTE_W-1:0]   rdData,
  output logic                timeoutOut
);

  logic [DIV_W-1:0]  divCnt;
  logic [UNIT_W-1:0] unitCnt;
  logic              active;
  logic [BYTE_W-1:0] txShift;
  logic [BYTE_W-1:0] wdHold;
  logic [BYTE_W-1:0] rxShift;
  logic [BYTE_W-1:0] cmdByte;

  assign cmdByte  = devAddr | {regIdx, 1'b0} | {{(BYTE_W-1){1'b0}}, ctl.dirWrite};
  assign stepDone = active && (divCnt == '0) && (unitCnt == '0);

  // step timer: each step holds its levels for units * (cfgDiv+1) clocks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt  <= '0;
      unitCnt <= '0;
      active  <= 1'b0;
    end else if (ctl.load) begin
      divCnt  <= cfgDiv;
      unitCnt <= ctl.units - UNIT_W'(1);
      active  <= 1'b1;
    end else if (ctl.stop) begin
      active  <= 1'b0;
    end else if (active) begin
      if (divCnt == '0) begin
        if (unitCnt != '0) begin
          unitCnt <= unitCnt - UNIT_W'(1);
          divCnt  <= cfgDiv;
        end
      end else begin
        divCnt <= divCnt - DIV_W'(1);
      end
    end
  end

  // line drivers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkOut <= 1'b0;
      sdOut   <= 1'b0;
    end else if (ctl.load) begin
      if (ctl.setClk) sclkOut <= ctl.clkVal;
      if (ctl.setData) begin
        case (ctl.dataSel)
          SD_HIGH: sdOut <= 1'b1;
          SD_TX:   sdOut <= txShift[0];
          default: sdOut <= 1'b0;
        endcase
      end
    end
  end

  // byte shifters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      wdHold  <= '0;
      rxShift <= '0;
    end else if (ctl.startAcc) begin
      txShift <= cmdByte;
      wdHold  <= wrData;
      rxShift <= '0;
    end else begin
      if (ctl.loadData)      txShift <= wdHold;
      else if (ctl.shiftTx)  txShift <= {1'b0, txShift[BYTE_W-1:1]};
      if (ctl.sampleRx)      rxShift <= {sdIn, rxShift[BYTE_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData     <= '0;
      timeoutOut <= 1'b0;
    end else begin
      if (ctl.latchRd) rdData <= rxShift;
      if (ctl.raiseTo)      timeoutOut <= 1'b1;
      else if (timeoutClr)  timeoutOut <= 1'b0;
    end
  end

endmodule

// File: rtl/dlm_ctrl.sv
module dlm_ctrl
  import dlm_pkg::*;
#(
  parameter int POLL_LIMIT   = 10,
  parameter int DUMMY_PULSES = 2,
  parameter int READ_TRAIL   = 3,
  parameter int WRITE_TAIL   = 2,
  parameter int RESET_PULSES = 30
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startIn,
  input  logic [1:0] opIn,
  input  logic       validN,
  input  logic       stepDone,
  output stepCtl_t   ctl,
  output logic       busyOut,
  output logic       doneOut
);

  localparam int MAX_LOOP = maxOf(maxOf(POLL_LIMIT, DUMMY_PULSES),
                                  maxOf(maxOf(READ_TRAIL, WRITE_TAIL), RESET_PULSES));
  localparam int CNT_W = $clog2(MAX_LOOP + 1);
  localparam int BIT_W = $clog2(BYTE_W);

  typedef enum logic [4:0] {
    S_IDLE, S_LEADL, S_LEADH, S_PREL, S_PREH, S_BITL, S_BITH,
    S_WTL, S_WTH, S_RGAP, S_POLLH, S_POLLL, S_POLLD,
    S_DATH, S_DATL, S_DUMH, S_DUML, S_TRH, S_TRL, S_TRD,
    S_T3H, S_T3L, S_RSTD, S_RSTH, S_RSTL, S_FIN
  } state_t;

  state_t           state, nxtState;
  logic [CNT_W-1:0] cnt, nxtCnt;
  logic [BIT_W-1:0] bitCnt, nxtBit;
  logic             second, nxtSecond;
  logic             isWrite;
  logic             go, startNow, loadDataNow, raiseNow;

  function automatic stepCtl_t entryOf(state_t s);
    stepCtl_t e;
    e = '0;
    e.load  = 1'b1;
    e.units = UNIT_W'(SHORT_UNITS);
    case (s)
      S_LEADL, S_RGAP, S_WTL: begin
        e.setClk = 1'b1; e.setData = 1'b1; e.dataSel = SD_LOW;
        e.units = UNIT_W'(LONG_UNITS);
      end
      S_PREL: begin
        e.setClk = 1'b1; e.setData = 1'b1; e.dataSel = SD_HIGH;
        e.units = UNIT_W'(LONG_UNITS);
      end
      S_BITL: begin
        e.setClk = 1'b1; e.setData = 1'b1; e.dataSel = SD_TX;
        e.units = UNIT_W'(LONG_UNITS);
      end
      S_BITH: begin
        e.setClk = 1'b1; e.clkVal = 1'b1; e.shiftTx = 1'b1;
      end
      S_LEADH, S_PREH, S_WTH, S_POLLH, S_DATH, S_DUMH, S_TRH, S_T3H, S_RSTH: begin
        e.setClk = 1'b1; e.clkVal = 1'b1;
      end
      S_POLLL, S_RSTL, S_FIN: e.setClk = 1'b1;
      S_POLLD: begin
        e.setData = 1'b1; e.dataSel = SD_HIGH;
      end
      S_DATL: begin
        e.setClk = 1'b1; e.sampleRx = 1'b1; e.units = UNIT_W'(LONG_UNITS);
      end
      S_DUML, S_TRL, S_T3L: begin
        e.setClk = 1'b1; e.units = UNIT_W'(LONG_UNITS);
      end
      S_TRD, S_RSTD: begin
        e.setClk = 1'b1; e.setData = 1'b1; e.dataSel = SD_LOW;
      end
      default: begin
        e.load = 1'b0; e.stop = 1'b1; e.latchRd = 1'b1;
      end
    endcase
    return e;
  endfunction

  always_comb begin
    nxtState    = state;
    nxtCnt      = cnt;
    nxtBit      = bitCnt;
    nxtSecond   = second;
    go          = 1'b0;
    startNow    = 1'b0;
    loadDataNow = 1'b0;
    raiseNow    = 1'b0;
    if (state == S_IDLE) begin
      if (startIn) begin
        go        = 1'b1;
        startNow  = 1'b1;
        nxtCnt    = '0;
        nxtSecond = 1'b0;
        nxtState  = opIn[1] ? S_RSTD : S_LEADL;
      end
    end else if (stepDone) begin
      go = 1'b1;
      case (state)
        S_LEADL: nxtState = S_LEADH;
        S_LEADH: nxtState = S_PREL;
        S_PREL:  nxtState = S_PREH;
        S_PREH:  begin nxtState = S_BITL; nxtBit = '0; end
        S_BITL:  nxtState = S_BITH;
        S_BITH: begin
          if (bitCnt == BIT_W'(BYTE_W-1)) begin
            nxtCnt = '0;
            if (isWrite && !second) begin
              nxtState = S_PREL; nxtSecond = 1'b1; loadDataNow = 1'b1;
            end else if (isWrite) begin
              nxtState = S_WTL;
            end else begin
              nxtState = S_RGAP;
            end
          end else begin
            nxtBit = bitCnt + BIT_W'(1); nxtState = S_BITL;
          end
        end
        S_WTL: nxtState = S_WTH;
        S_WTH: begin
          if (cnt == CNT_W'(WRITE_TAIL-1)) nxtState = S_FIN;
          else begin nxtCnt = cnt + CNT_W'(1); nxtState = S_WTL; end
        end
        S_RGAP:  nxtState = S_POLLH;
        S_POLLH: nxtState = S_POLLL;
        S_POLLL: nxtState = S_POLLD;
        S_POLLD: begin
          if (!validN) begin
            nxtState = S_DATH; nxtBit = '0;
          end else if (cnt == CNT_W'(POLL_LIMIT-1)) begin
            nxtState = S_DUMH; nxtCnt = '0; raiseNow = 1'b1;
          end else begin
            nxtCnt = cnt + CNT_W'(1); nxtState = S_POLLH;
          end
        end
        S_DATH: nxtState = S_DATL;
        S_DATL: begin
          if (bitCnt == BIT_W'(BYTE_W-1)) nxtState = S_TRH;
          else begin nxtBit = bitCnt + BIT_W'(1); nxtState = S_DATH; end
        end
        S_DUMH: nxtState = S_DUML;
        S_DUML: begin
          if (cnt == CNT_W'(DUMMY_PULSES-1)) nxtState = S_TRH;
          else begin nxtCnt = cnt + CNT_W'(1); nxtState = S_DUMH; end
        end
        S_TRH: nxtState = S_TRL;
        S_TRL: nxtState = S_TRD;
        S_TRD: begin nxtState = S_T3H; nxtCnt = '0; end
        S_T3H: nxtState = S_T3L;
        S_T3L: begin
          if (cnt == CNT_W'(READ_TRAIL-1)) nxtState = S_FIN;
          else begin nxtCnt = cnt + CNT_W'(1); nxtState = S_T3H; end
        end
        S_RSTD: begin nxtState = S_RSTH; nxtCnt = '0; end
        S_RSTH: nxtState = S_RSTL;
        S_RSTL: begin
          if (cnt == CNT_W'(RESET_PULSES-1)) nxtState = S_FIN;
          else begin nxtCnt = cnt + CNT_W'(1); nxtState = S_RSTH; end
        end
        default: nxtState = S_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl = '0;
    if (go) begin
      ctl          = entryOf(nxtState);
      ctl.startAcc = startNow;
      ctl.dirWrite = startNow && (opIn == 2'b01);
      ctl.loadData = loadDataNow;
      ctl.raiseTo  = raiseNow;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      cnt     <= '0;
      bitCnt  <= '0;
      second  <= 1'b0;
      isWrite <= 1'b0;
      doneOut <= 1'b0;
    end else begin
      state   <= nxtState;
      cnt     <= nxtCnt;
      bitCnt  <= nxtBit;
      second  <= nxtSecond;
      doneOut <= go && (state == S_FIN);
      if (startNow) isWrite <= (opIn == 2'b01);
    end
  end

  assign busyOut = (state != S_IDLE);

endmodule

// File: rtl/dongle_link_master.sv
module dongle_link_master
  import dlm_pkg::*;
#(
  parameter int DIV_W        = 8,
  parameter int POLL_LIMIT   = 10,
  parameter int DUMMY_PULSES = 2,
  parameter int READ_TRAIL   = 3,
  parameter int WRITE_TAIL   = 2,
  parameter int RESET_PULSES = 30
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  cfgDiv,
  input  logic              startIn,
  input  logic [1:0]        opIn,
  input  logic [7:0]        devAddr,
  input  logic [6:0]        regIdx,
  input  logic [7:0]        wrData,
  input  logic              timeoutClr,
  input  logic              validN,
  input  logic              sdIn,
  output logic              sclkOut,
  output logic              sdOut,
  output logic [7:0]        rdData,
  output logic              busyOut,
  output logic              doneOut,
  output logic              timeoutOut
);

  stepCtl_t ctl;
  logic     stepDone;

  dlm_ctrl #(
    .POLL_LIMIT  (POLL_LIMIT),
    .DUMMY_PULSES(DUMMY_PULSES),
    .READ_TRAIL  (READ_TRAIL),
    .WRITE_TAIL  (WRITE_TAIL),
    .RESET_PULSES(RESET_PULSES)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .startIn (startIn),
    .opIn    (opIn),
    .validN  (validN),
    .stepDone(stepDone),
    .ctl     (ctl),
    .busyOut (busyOut),
    .doneOut (doneOut)
  );

  dlm_datapath #(
    .DIV_W(DIV_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cfgDiv    (cfgDiv),
    .devAddr   (devAddr),
    .regIdx    (regIdx),
    .wrData    (wrData),
    .timeoutClr(timeoutClr),
    .sdIn      (sdIn),
    .ctl       (ctl),
    .stepDone  (stepDone),
    .sclkOut   (sclkOut),
    .sdOut     (sdOut),
    .rdData    (rdData),
    .timeoutOut(timeoutOut)
  );

endmodule

// File: rtl/dlm_checker.sv
module dlm_checker (
  input logic clk,
  input logic rstN,
  input logic busyOut,
  input logic doneOut,
  input logic sclkOut,
  input logic timeoutOut,
  input logic timeoutClr
);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);

  // R8
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> (!busyOut && $past(busyOut)));

  // R9
  idle_clk_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busyOut |-> !sclkOut);

  // R9
  clk_moves_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sclkOut) |-> (busyOut || $past(busyOut)));

  // R10
  timeout_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (timeoutOut && !timeoutClr) |=> timeoutOut);

endmodule

bind dongle_link_master dlm_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busyOut   (busyOut),
  .doneOut   (doneOut),
  .sclkOut   (sclkOut),
  .timeoutOut(timeoutOut),
  .timeoutClr(timeoutClr)
);

// File: tb/tb_dongle_link_master.sv
`timescale 1ns/1ps
module tb_dongle_link_master;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] cfgDiv = '0;
  logic       startIn = 1'b0;
  logic [1:0] opIn = '0;
  logic [7:0] devAddr = '0;
  logic [6:0] regIdx = '0;
  logic [7:0] wrData = '0;
  logic       timeoutClr = 1'b0;
  logic       validN = 1'b1;
  logic       sdIn = 1'b0;
  logic       sclkOut, sdOut, busyOut, doneOut, timeoutOut;
  logic [7:0] rdData;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // dongle model state
  int   edgeNum = 0;
  int   runLen  = 0;
  logic prevSclk = 1'b0;
  logic prevBusy = 1'b0;
  logic logBits [0:63];
  int   lowLen  [0:63];
  int   highLen [0:63];
  logic modelRd = 1'b0;
  int   modelDly = 0;
  logic [7:0] modelByte = '0;

  always #2.5 clk = ~clk;

  dongle_link_master dut (
    .clk(clk), .rstN(rstN), .cfgDiv(cfgDiv), .startIn(startIn), .opIn(opIn),
    .devAddr(devAddr), .regIdx(regIdx), .wrData(wrData), .timeoutClr(timeoutClr),
    .validN(validN), .sdIn(sdIn), .sclkOut(sclkOut), .sdOut(sdOut),
    .rdData(rdData), .busyOut(busyOut), .doneOut(doneOut), .timeoutOut(timeoutOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // dongle model and line monitor, sampled away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (busyOut && !prevBusy) begin
      edgeNum = 0;
      runLen  = 1;
      validN  <= 1'b1;
    end else if (sclkOut == prevSclk) begin
      runLen++;
    end else begin
      if (sclkOut) begin
        edgeNum++;
        if (edgeNum < 64) begin
          lowLen[edgeNum]  = runLen;
          logBits[edgeNum] = sdOut;
        end
        if (modelRd && edgeNum == 10 + modelDly) validN <= 1'b0;
        if (modelRd && edgeNum >= 11 + modelDly && edgeNum <= 18 + modelDly)
          sdIn <= modelByte[edgeNum - 11 - modelDly];
      end else if (edgeNum < 64) begin
        highLen[edgeNum] = runLen;
      end
      runLen = 1;
    end
    prevSclk = sclkOut;
    prevBusy = busyOut;
    if (cycles == 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic waitDone(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (doneOut) begin ok = 1'b1; break; end
    end
  endtask

  task automatic startOp(input logic [1:0] op, input logic [7:0] a, input logic [6:0] ix,
                         input logic [7:0] wd, input int dly, input logic [7:0] rb);
    @(negedge clk);
    modelRd   = (op == 2'b00);
    modelDly  = dly;
    modelByte = rb;
    opIn = op; devAddr = a; regIdx = ix; wrData = wd;
    startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
  endtask

  function automatic logic [7:0] gather(input int first);
    logic [7:0] v;
    for (int i = 0; i < 8; i++) v[i] = logBits[first + i];
    return v;
  endfunction

  task automatic timingCheck(input int div, input int lastLow, input int lowUnits, input string req);
    bit ok = 1'b1;
    int bad = 0;
    for (int e = 1; e <= edgeNum; e++) if (highLen[e] != div + 1) begin ok = 1'b0; bad = highLen[e]; end
    for (int e = 2; e <= lastLow; e++) if (lowLen[e] != lowUnits * (div + 1)) begin ok = 1'b0; bad = lowLen[e]; end
    check(ok, req, bad, div + 1);
  endtask

  task automatic doWrite(input int div, input logic [7:0] a, input logic [6:0] ix, input logic [7:0] wd);
    bit ok;
    logic [7:0] cmd;
    cfgDiv = 8'(div);
    cmd = a | {ix, 1'b0} | 8'h01;
    startOp(2'b01, a, ix, wd, 0, 8'h00);
    waitDone(ok);
    check(ok, "R8 write done", int'(ok), 1);
    check(!busyOut, "R8 busy low at done", int'(busyOut), 0);
    check(edgeNum == 21, "R2 write edges", edgeNum, 21);
    check(logBits[1] == 1'b0 && logBits[2] == 1'b1, "R1 lead/preamble", int'({logBits[1], logBits[2]}), 1);
    check(gather(3) == cmd, "R1 write cmd byte", int'(gather(3)), int'(cmd));
    check(logBits[11] == 1'b1 && gather(12) == wd, "R2 data byte", int'(gather(12)), int'(wd));
    check(logBits[20] == 1'b0 && logBits[21] == 1'b0, "R2 tail data low", int'({logBits[20], logBits[21]}), 0);
    timingCheck(div, 21, 2, "R7 write phases");
    @(negedge clk);
    check(!sclkOut, "R9 clk low after write", int'(sclkOut), 0);
  endtask

  task automatic doRead(input int div, input int dly, input logic [7:0] a, input logic [6:0] ix, input logic [7:0] rb);
    bit ok;
    bit tmo;
    logic [7:0] cmd;
    int expEdges;
    tmo = (dly > 10);
    cfgDiv = 8'(div);
    @(negedge clk); timeoutClr = 1'b1; @(negedge clk); timeoutClr = 1'b0;
    cmd = a | {ix, 1'b0};
    startOp(2'b00, a, ix, 8'h00, dly, rb);
    waitDone(ok);
    expEdges = tmo ? 26 : 22 + dly;
    check(ok, "R8 read done", int'(ok), 1);
    check(edgeNum == expEdges, tmo ? "R4 timeout edges" : "R3 read edges", edgeNum, expEdges);
    check(gather(3) == cmd, "R1 read cmd byte", int'(gather(3)), int'(cmd));
    check(rdData == (tmo ? 8'h00 : rb), tmo ? "R4 zero data" : "R3 read data", int'(rdData), int'(tmo ? 8'h00 : rb));
    check(timeoutOut == tmo, tmo ? "R4 timeout flag" : "R3 no timeout", int'(timeoutOut), int'(tmo));
    check(logBits[expEdges] == 1'b0 && logBits[expEdges-1] == 1'b0 && logBits[expEdges-2] == 1'b0,
          "R5 trailer data low", int'({logBits[expEdges-2], logBits[expEdges-1], logBits[expEdges]}), 0);
    timingCheck(div, 10, 2, "R7 read phases");
    validN = 1'b1;
  endtask

  task automatic doReset(input int div);
    bit ok;
    bit allLow = 1'b1;
    cfgDiv = 8'(div);
    startOp(2'b10, 8'h00, 7'h00, 8'h00, 0, 8'h00);
    waitDone(ok);
    check(ok && edgeNum == 30, "R6 reset pulses", edgeNum, 30);
    for (int e = 1; e <= 30; e++) if (logBits[e] != 1'b0) allLow = 1'b0;
    check(allLow, "R6 reset data low", int'(allLow), 1);
    timingCheck(div, 30, 1, "R7 reset phases");
  endtask

  initial begin
    bit ok;
    int keep;
    repeat (4) @(negedge clk);
    check(!busyOut && !sclkOut && !doneOut && !timeoutOut && rdData == 8'h00,
          "R9 reset state", int'({busyOut, sclkOut, doneOut, timeoutOut}), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    for (int div = 0; div < 3; div++) begin
      doWrite(div, 8'h40 + 8'(div), 7'(div * 5 + 1), 8'hA5 ^ 8'(div * 29));
      for (int d = 1; d <= 11; d++)
        doRead(div, d, 8'h40, 7'(d), 8'h3C ^ 8'(d * 37 + div));
      doReset(div);
    end

    // R8: start while busy is ignored
    cfgDiv = 8'd1;
    startOp(2'b01, 8'h80, 7'h15, 8'h96, 0, 8'h00);
    repeat (30) @(negedge clk);
    opIn = 2'b10; startIn = 1'b1; @(negedge clk); startIn = 1'b0; opIn = 2'b01;
    waitDone(ok);
    check(edgeNum == 21 && gather(12) == 8'h96, "R8 busy start ignored", edgeNum, 21);
    keep = edgeNum;
    repeat (40) @(negedge clk);
    check(!busyOut && edgeNum == keep, "R8 no queued access", edgeNum, keep);

    // R10: sticky timeout, then clear
    doRead(0, 11, 8'h40, 7'h02, 8'h00);
    startOp(2'b00, 8'h40, 7'h03, 8'h00, 4, 8'h77);
    waitDone(ok);
    validN = 1'b1;
    check(timeoutOut, "R10 timeout sticky", int'(timeoutOut), 1);
    @(negedge clk); timeoutClr = 1'b1; @(negedge clk); timeoutClr = 1'b0;
    @(negedge clk);
    check(!timeoutOut, "R10 timeout cleared", int'(timeoutOut), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule